// File: doc/BRIEF.md
# Move-Triggered Arithmetic Function Unit

This block is one function unit of a processor whose only instruction is a data move. Software never issues an opcode to it. Instead it writes values into two of the unit's registers through socket write ports. A write to the operand register just stores a value. A write to the trigger register starts one operation: the held operand is combined with the value being written, and the answer lands in the result register a fixed number of cycles later. The operation (add, subtract or equality compare) is fixed for each instance by a parameter.

The unit has its own internal pipeline, so a new trigger can be accepted on every cycle while earlier operations are still moving through it. It has no interlocks of any kind. Whoever schedules the moves must read the result register no earlier than the fixed latency allows. That scheduler must also copy a result away before a later result overwrites it.

The compare variant yields a single flag, zero-extended to the full word, that is intended for a predicate register. A one-cycle result-valid flag marks each cycle in which the result register has just received a new value.

Top module: `tt_func_unit`

## Requirements
- R1: A write with `wr_valid[p]`=1 and `wr_sel[p]`=0 loads the operand register. The operand register keeps that value through any number of triggers until a later operand write replaces it.
- R2: A write with `wr_sel[p]`=1 (trigger) is sampled at a rising edge. At the rising edge LATENCY−1 edges later, the result is written to `rd_data`, and `rd_valid` is 1 for exactly that one cycle. No result and no `rd_valid` pulse ever occurs without a trigger.
- R3: When an operand write and a trigger write are sampled at the same edge, the operation uses the newly written operand value.
- R4: Triggers on consecutive cycles are all accepted. Each one produces its own result, in trigger order, one per cycle.
- R5: `rd_data` keeps its value until the next result arrives. No other input changes it.
- R6: The result depends on OP. For FU_ADD it is operand + trigger modulo 2^DATA_W. For FU_SUB it is operand − trigger modulo 2^DATA_W. For FU_EQ it is 1 when operand equals trigger and 0 otherwise, with bits DATA_W−1..1 always zero.
- R7: Port p carries data in bits `wr_data[p*DATA_W +: DATA_W]`. When several ports write the same target register in one cycle, the highest-numbered port wins.
- R8: While reset is held, and after reset until the first result, `rd_data` is 0 and `rd_valid` is 0. The operand register resets to 0.
- R9: A port with `wr_valid[p]`=0 has no effect, whatever its select and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | NUM_PORTS | Per-port write strobe |
| wr_sel | input | NUM_PORTS | Per-port target: 0 operand register, 1 trigger register |
| wr_data | input | NUM_PORTS*DATA_W | Per-port write data, port p in slice p |
| rd_data | output | DATA_W | Result register contents |
| rd_valid | output | 1 | One-cycle pulse when the result register has just been written |

## Verification
The hazard of interest is an operand write and a trigger write landing in the same cycle. In that case the operation must use the fresh operand, not the stored one. The bench provokes this by driving the operand on one port and the trigger on another in the same cycle. It also drives two ports at one target to exercise port priority, and mixes both patterns into a long random run. Three instances with different operations and latencies run side by side. Each is compared on every clock against a queue-based model that computes the expected result and its arrival cycle.

// File: rtl/tt_fu_pkg.sv
package tt_fu_pkg;
  typedef enum logic [1:0] {
    FU_ADD = 2'd0,
    FU_SUB = 2'd1,
    FU_EQ  = 2'd2
  } fu_op_e;

  localparam logic SEL_OPND = 1'b0;
  localparam logic SEL_TRIG = 1'b1;
endpackage

// File: rtl/tt_socket_merge.sv
// Merges the socket write ports into one operand write and one trigger write.
// Higher-numbered ports override lower ones (R7); invalid ports are ignored (R9).
module tt_socket_merge
  import tt_fu_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 32
) (
  input  logic [NUM_PORTS-1:0]        wr_valid,
  input  logic [NUM_PORTS-1:0]        wr_sel,
  input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
  output logic                        opnd_we,
  output logic [DATA_W-1:0]           opnd_wd,
  output logic                        trig_we,
  output logic [DATA_W-1:0]           trig_wd
);
  always_comb begin
    opnd_we = 1'b0;
    opnd_wd = '0;
    trig_we = 1'b0;
    trig_wd = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (wr_valid[p] && (wr_sel[p] == SEL_OPND)) begin
        opnd_we = 1'b1;
        opnd_wd = wr_data[p*DATA_W +: DATA_W];
      end
      if (wr_valid[p] && (wr_sel[p] == SEL_TRIG)) begin
        trig_we = 1'b1;
        trig_wd = wr_data[p*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/tt_operand_reg.sv
// Software-visible operand register with same-cycle forwarding (R1, R3).
module tt_operand_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] eff
);
  logic [DATA_W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (we) q_next = wd;
  end

  assign eff = q_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= q_next;
  end

  // R1: without an operand write the held operand never changes
  a_r1_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/tt_exec_pipe.sv
// Computes the selected operation and carries it through LATENCY-1 stages.
module tt_exec_pipe
  import tt_fu_pkg::*;
#(
  parameter int     DATA_W  = 32,
  parameter int     LATENCY = 2,
  parameter fu_op_e OP      = FU_ADD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] trig,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int STAGES = LATENCY - 1;

  logic [DATA_W-1:0] calc;

  generate
    if (OP == FU_SUB) begin : g_sub
      assign calc = opnd - trig;
    end else if (OP == FU_EQ) begin : g_eq
      assign calc = {{(DATA_W-1){1'b0}}, (opnd == trig)};
    end else begin : g_add
      assign calc = opnd + trig;
    end
  endgenerate

  generate
    if (STAGES == 0) begin : g_direct
      assign out_valid = start;
      assign out_data  = calc;
    end else begin : g_staged
      logic              stg_v [STAGES];
      logic [DATA_W-1:0] stg_d [STAGES];
      logic              stg_v_n [STAGES];
      logic [DATA_W-1:0] stg_d_n [STAGES];

      always_comb begin
        stg_v_n[0] = start;
        stg_d_n[0] = calc;
        for (int s = 1; s < STAGES; s++) begin
          stg_v_n[s] = stg_v[s-1];
          stg_d_n[s] = stg_d[s-1];
        end
      end

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_v[s] <= 1'b0;
          else        stg_v[s] <= stg_v_n[s];
        end
        always_ff @(posedge clk) begin
          if (stg_v_n[s]) stg_d[s] <= stg_d_n[s];
        end
      end

      assign out_valid = stg_v[STAGES-1];
      assign out_data  = stg_d[STAGES-1];

      // R2: the first stage is only loaded by a trigger write
      a_r2_stage_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !stg_v[0]);
    end
  endgenerate
endmodule

// File: rtl/tt_result_reg.sv
// Software-visible result register: holds until overwritten (R5).
module tt_result_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] q,
  output logic              fresh
);
  logic [DATA_W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (in_valid) q_next = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= in_valid;
      if (in_valid) q <= q_next;
    end
  end

  // R5: no arriving result means the register keeps its value
  a_r5_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(q));
endmodule

// File: rtl/tt_func_unit.sv
module tt_func_unit
  import tt_fu_pkg::*;
#(
  parameter int     NUM_PORTS = 2,
  parameter int     DATA_W    = 32,
  parameter int     LATENCY   = 2,
  parameter fu_op_e OP        = FU_ADD
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        wr_valid,
  input  logic [NUM_PORTS-1:0]        wr_sel,
  input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_valid
);
  localparam int CNT_W = $clog2(LATENCY + 2);

  logic              opnd_we, trig_we;
  logic [DATA_W-1:0] opnd_wd, trig_wd;
  logic [DATA_W-1:0] opnd_q, opnd_eff;
  logic              pipe_v;
  logic [DATA_W-1:0] pipe_d;

  tt_socket_merge #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_merge (
    .wr_valid (wr_valid),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .opnd_we  (opnd_we),
    .opnd_wd  (opnd_wd),
    .trig_we  (trig_we),
    .trig_wd  (trig_wd)
  );

  tt_operand_reg #(.DATA_W(DATA_W)) u_opnd (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (opnd_we),
    .wd    (opnd_wd),
    .q     (opnd_q),
    .eff   (opnd_eff)
  );

  tt_exec_pipe #(.DATA_W(DATA_W), .LATENCY(LATENCY), .OP(OP)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (trig_we),
    .opnd      (opnd_eff),
    .trig      (trig_wd),
    .out_valid (pipe_v),
    .out_data  (pipe_d)
  );

  tt_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (pipe_v),
    .in_data  (pipe_d),
    .q        (rd_data),
    .fresh    (rd_valid)
  );

  // In-flight bookkeeping used only by the assertions below.
  logic [CNT_W-1:0] inflight, inflight_n;
  always_comb begin
    inflight_n = inflight;
    if (trig_we && !rd_valid)      inflight_n = inflight + 1'b1;
    else if (!trig_we && rd_valid) inflight_n = inflight - 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight_n;
  end

  // R2: a result pulse always belongs to an accepted trigger
  a_r2_valid_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (inflight != '0));
  // R4: pipelining never lets more than LATENCY operations be outstanding
  a_r4_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CNT_W'(LATENCY));
  // R6: compare results carry only bit 0
  a_r6_cmp_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ((OP == FU_EQ) && rd_valid) |-> (rd_data[DATA_W-1:1] == '0));
endmodule

// File: tb/tb_tt_func_unit.sv
module tb_tt_func_unit;
  import tt_fu_pkg::*;

  localparam int NP = 2;
  localparam int W  = 32;
  localparam int NU = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     wv, ws;
  logic [NP*W-1:0]   wd;
  logic [W-1:0]      rdat [NU];
  logic              rval [NU];

  always #5 clk = ~clk;

  tt_func_unit #(.NUM_PORTS(NP), .DATA_W(W), .LATENCY(2), .OP(FU_ADD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_sel(ws), .wr_data(wd),
    .rd_data(rdat[0]), .rd_valid(rval[0]));
  tt_func_unit #(.NUM_PORTS(NP), .DATA_W(W), .LATENCY(3), .OP(FU_SUB)) dut_sub (
    .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_sel(ws), .wr_data(wd),
    .rd_data(rdat[1]), .rd_valid(rval[1]));
  tt_func_unit #(.NUM_PORTS(NP), .DATA_W(W), .LATENCY(1), .OP(FU_EQ)) dut_eq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_sel(ws), .wr_data(wd),
    .rd_data(rdat[2]), .rd_valid(rval[2]));

  // ---------------- reference model ----------------
  int          lat [NU] = '{2, 3, 1};
  logic [W:0]  mq  [NU][$];
  logic [W-1:0] m_opnd;
  logic [W-1:0] m_res [NU];
  logic         m_val [NU];

  function automatic logic [W-1:0] calc(int u, logic [W-1:0] a, logic [W-1:0] b);
    if (u == 0) return a + b;
    if (u == 1) return a - b;
    return (a == b) ? 32'd1 : 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_opnd = '0;
      for (int u = 0; u < NU; u++) begin
        mq[u].delete();
        m_res[u] = '0;
        m_val[u] = 1'b0;
      end
    end else begin
      logic [W-1:0] op_v, tr_v;
      logic         tr_e;
      op_v = m_opnd;
      tr_v = '0;
      tr_e = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (wv[p] && !ws[p]) op_v = wd[p*W +: W];
        if (wv[p] &&  ws[p]) begin tr_e = 1'b1; tr_v = wd[p*W +: W]; end
      end
      for (int u = 0; u < NU; u++) begin
        logic [W:0] e;
        mq[u].push_back({tr_e, calc(u, op_v, tr_v)});
        m_val[u] = 1'b0;
        if (mq[u].size() >= lat[u]) begin
          e = mq[u].pop_front();
          m_val[u] = e[W];
          if (e[W]) m_res[u] = e[W-1:0];
        end
      end
      m_opnd = op_v;
    end
  end

  // ---------------- checking ----------------
  int    n_cmp = 0;
  int    n_bad = 0;
  string req   = "R8";
  bit    done  = 1'b0;

  task automatic compare_all();
    for (int u = 0; u < NU; u++) begin
      n_cmp++;
      if (rval[u] !== m_val[u] || rdat[u] !== m_res[u]) begin
        n_bad++;
        $display("FAIL %s unit%0d: actual valid=%0b data=%h expected valid=%0b data=%h",
                 req, u, rval[u], rdat[u], m_val[u], m_res[u]);
      end
    end
  endtask

  task automatic step(input logic v0, input logic s0, input logic [W-1:0] d0,
                      input logic v1, input logic s1, input logic [W-1:0] d1);
    wv = {v1, v0};
    ws = {s1, s0};
    wd = {d1, d0};
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, '0);
  endtask

  initial begin
    rst_n = 1'b0;
    wv = '0; ws = '0; wd = '0;
    repeat (3) @(negedge clk);
    req = "R8"; compare_all();                        // R8 during reset
    rst_n = 1'b1;
    idle(2);                                          // R8 after release

    // R1 / R6: load operand once, trigger several times
    req = "R1";
    step(1, SEL_OPND, 32'd100, 0, 0, '0);
    step(1, SEL_TRIG, 32'd7, 0, 0, '0);
    idle(3);
    step(1, SEL_TRIG, 32'd100, 0, 0, '0);             // equal case for compare
    idle(3);
    req = "R6";
    step(1, SEL_OPND, 32'h0000_0001, 0, 0, '0);
    step(1, SEL_TRIG, 32'hFFFF_FFFF, 0, 0, '0);       // add wraps, sub borrows
    idle(4);

    // R3: operand on port 0 and trigger on port 1 in the same cycle
    req = "R3";
    step(1, SEL_OPND, 32'd55, 1, SEL_TRIG, 32'd55);
    idle(4);
    step(1, SEL_TRIG, 32'd9, 1, SEL_OPND, 32'd1234);
    idle(4);

    // R4: a trigger on every cycle
    req = "R4";
    for (int i = 0; i < 10; i++) step(1, SEL_TRIG, 32'(i * 37 + 1230), 0, 0, '0);
    // R5: results held while idle
    req = "R5";
    idle(5);
    step(1, SEL_OPND, 32'hDEAD_0000, 0, 0, '0);
    idle(3);

    // R7: two ports at one target in the same cycle
    req = "R7";
    step(1, SEL_OPND, 32'd11, 1, SEL_OPND, 32'd22);
    step(1, SEL_TRIG, 32'd11, 1, SEL_TRIG, 32'd22);
    idle(4);

    // R9: invalid ports carrying junk
    req = "R9";
    step(0, SEL_TRIG, 32'hAAAA_5555, 0, SEL_OPND, 32'h1234_5678);
    step(0, SEL_OPND, 32'h0F0F_0F0F, 0, SEL_TRIG, 32'h7777_7777);
    idle(4);
    step(1, SEL_TRIG, 32'd22, 0, 0, '0);
    idle(4);

    // R2: random mix of moves
    req = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      a = (i % 3 == 0) ? ($urandom & 32'h3) : $urandom;
      b = (i % 3 == 0) ? ($urandom & 32'h3) : $urandom;
      step(1'($urandom), 1'($urandom), a, 1'($urandom), 1'($urandom), b);
    end
    idle(5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog: actual hung expected completion", req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule